// File: doc/BRIEF.md
# Nonvolatile Byte Array Programming Sequencer

This block controls a 256-byte nonvolatile array, modelled inside the block as a register array, together with one extra security byte. Software drives it through a byte-wide register bus with a register select, a write strobe, a read strobe, write data and read data. Five registers are reachable: control, timing, address-high, address-low and data. In byte mode the data register always mirrors the addressed byte. Writing the data register starts a program operation. Control codes select two bulk erase operations: an 8-byte row erase and a whole-array erase.

A byte program reads the old content first. If the byte is already clear (00H), only a write phase runs. Otherwise an erase phase runs first and then a write phase. Each phase lasts (timing + 1) × 16 clock cycles. While an operation runs, a busy flag is visible in the control register and every register write is refused. When the operation ends, the busy flag drops and a completion flag is set. The completion flag drives an interrupt output through an enable bit.

On reset the array is filled with a parameterised value (FFH by default), which models an unprogrammed part.

Top module: `nvbyte_seq`

## Requirements
- R1: After reset, reads return control 00H (select 0), timing 08H (select 1), address-high 80H (select 2) and address-low 00H (select 3). Select 4 is the data register. A read strobe captures the selected register into the read data at the next clock edge.
- R2: In byte mode (control bits 3..0 = 0000), the data register presents the byte at the loaded address from the second clock edge after an address write.
- R3: In byte mode, a data-register write to a byte that is not 00H runs an erase phase and then a write phase. Busy lasts two phase lengths, and the byte then holds the written value.
- R4: In byte mode, a data-register write to a byte that already holds 00H runs only the write phase. Busy lasts one phase length.
- R5: One phase lasts (T + 1) × 16 clock cycles, where T is the timing register value. Busy (control bit 5) rises at the edge that accepts the data write.
- R6: With control bits 3..0 = 1100, a data write clears to 00H the 8 bytes that share address bits 7..3. The low three address bits and the data value are ignored, no other byte changes, and busy lasts one phase length.
- R7: With control bits 3..0 = 1010, a data write clears all 256 bytes and the security byte in one phase length, whatever the address and data.
- R8: At the edge where busy drops, control bit 7 (completion flag) becomes 1. Software can set or clear bit 7 by a control write. The irq output equals bit 7 AND bit 6 (interrupt enable).
- R9: Control bit 5 cannot be written by software, and control bit 4 always reads 0.
- R10: While busy, writes to any register are ignored. Reads return the values latched before the operation, and the data register holds the value being programmed.
- R11: Address-high bit 7 = 1 with address-low 00H selects the security byte, which is separate from array byte 0. In every other case, address-low indexes the array.
- R12: A data write under any mode code other than 0000, 1100 or 1010 starts nothing: busy stays 0 and no byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 8 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on a read strobe |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle, the assertions check the following:
- each busy period ends after exactly one or two phase lengths for the current timing value;
- the completion flag is set when busy falls;
- address, mode and timing hold still while busy;
- a control read reports the busy state of the cycle in which it was taken;
- an unknown mode code never starts an operation.

Only the bench scenarios can show which bytes the operations actually change:
- the read-back of every address after the byte-program and row-erase sweeps;
- the choice between a write-only and an erase-then-write program;
- separation of the security byte from array byte 0;
- the refusal of writes made while busy.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ERASE = 2'd1,
      ST_WRITE = 2'd2
   } seq_st_t;

   typedef enum logic [1:0] {
      OP_BYTE  = 2'd0,
      OP_ROW   = 2'd1,
      OP_BLOCK = 2'd2
   } op_kind_t;

   typedef struct packed {
      logic       flag;
      logic       ien;
      logic [3:0] mode;
   } ctrl_t;

   localparam logic [7:0] SEL_CTRL = 8'd0;
   localparam logic [7:0] SEL_TIM  = 8'd1;
   localparam logic [7:0] SEL_AHI  = 8'd2;
   localparam logic [7:0] SEL_ALO  = 8'd3;
   localparam logic [7:0] SEL_DATA = 8'd4;

   localparam logic [3:0] MODE_BYTE  = 4'h0;
   localparam logic [3:0] MODE_ROW   = 4'hC;
   localparam logic [3:0] MODE_BLOCK = 4'hA;

endpackage

// File: rtl/nvbyte_phase_timer.sv
module nvbyte_phase_timer
   import nvbyte_pkg::*;
#(
   parameter int TW = 8,
   parameter int SH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] tim,
   output logic          expire
);
   localparam int CW = TW + SH;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_c;

   assign last_c = {tim, {SH{1'b1}}};
   assign expire = run && (cnt_q == last_c);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || expire)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/nvbyte_array.sv
module nvbyte_array #(
   parameter int          AW   = 8,
   parameter int          RW   = 3,
   parameter int          DW   = 8,
   parameter logic [7:0]  FILL = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] idx,
   input  logic          sec,
   output logic [DW-1:0] rd_byte,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_val,
   input  logic          clr_byte,
   input  logic          clr_row,
   input  logic          clr_all
);
   localparam int DEPTH = 1 << AW;
   localparam int ROWN  = 1 << RW;

   logic [DW-1:0] mem_q [DEPTH];
   logic [DW-1:0] sec_q;

   assign rd_byte = sec ? sec_q : mem_q[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(FILL);
         sec_q <= DW'(FILL);
      end else if (clr_all) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         sec_q <= '0;
      end else if (clr_row) begin
         for (int k = 0; k < ROWN; k++)
            mem_q[{idx[AW-1:RW], RW'(k)}] <= '0;
      end else if (clr_byte) begin
         if (sec) sec_q <= '0;
         else     mem_q[idx] <= '0;
      end else if (wr_en) begin
         if (sec) sec_q <= wr_val;
         else     mem_q[idx] <= wr_val;
      end
   end
endmodule

// File: rtl/nvbyte_regs.sv
module nvbyte_regs
   import nvbyte_pkg::*;
#(
   parameter int         DW      = 8,
   parameter int         SW      = 8,
   parameter logic [7:0] TIM_RST = 8'h08,
   parameter logic [7:0] AHI_RST = 8'h80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sel,
   input  logic          wr,
   input  logic          rd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          busy,
   input  logic          done,
   input  logic [DW-1:0] mem_byte,
   output ctrl_t         ctrl,
   output logic [DW-1:0] tim,
   output logic [DW-1:0] ahi,
   output logic [DW-1:0] alo,
   output logic [DW-1:0] data,
   output logic          go
);
   logic          wr_ok;
   logic [DW-1:0] ctrl_rd;

   assign wr_ok   = wr && !busy;
   assign go      = wr_ok && (sel == SW'(SEL_DATA));
   assign ctrl_rd = {ctrl.flag, ctrl.ien, busy, 1'b0, ctrl.mode};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         tim   <= DW'(TIM_RST);
         ahi   <= DW'(AHI_RST);
         alo   <= '0;
         data  <= '0;
         rdata <= '0;
      end else begin
         if (done) ctrl.flag <= 1'b1;
         if (!busy && ctrl.mode == MODE_BYTE) data <= mem_byte;
         if (wr_ok) begin
            case (sel)
               SW'(SEL_CTRL): begin
                  ctrl.flag <= wdata[7];
                  ctrl.ien  <= wdata[6];
                  ctrl.mode <= wdata[3:0];
               end
               SW'(SEL_TIM):  tim  <= wdata;
               SW'(SEL_AHI):  ahi  <= wdata;
               SW'(SEL_ALO):  alo  <= wdata;
               SW'(SEL_DATA): data <= wdata;
               default: ;
            endcase
         end
         if (rd) begin
            case (sel)
               SW'(SEL_CTRL): rdata <= ctrl_rd;
               SW'(SEL_TIM):  rdata <= tim;
               SW'(SEL_AHI):  rdata <= ahi;
               SW'(SEL_ALO):  rdata <= alo;
               SW'(SEL_DATA): rdata <= data;
               default:       rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
   import nvbyte_pkg::*;
#(
   parameter int         AW         = 8,
   parameter int         RW         = 3,
   parameter int         DW         = 8,
   parameter int         SW         = 8,
   parameter int         TICK_SHIFT = 4,
   parameter logic [7:0] TIM_RST    = 8'h08,
   parameter logic [7:0] FILL       = 8'hFF,
   parameter bit         SKIP_CLEAN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] bus_sel,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq
);
   if (DW != 8) begin : g_bad_dw
      $error("nvbyte_seq: control layout needs DW == 8");
   end
   if (AW > DW || AW <= RW) begin : g_bad_aw
      $error("nvbyte_seq: need RW < AW <= DW");
   end
   if (SW < 3) begin : g_bad_sw
      $error("nvbyte_seq: select too narrow");
   end

   ctrl_t         ctrl;
   logic [DW-1:0] tim, ahi, alo, data, mem_byte;
   logic          go, expire, busy, done, need_erase;
   logic          sec_sel, clr_byte, clr_row, clr_all, wr_en;
   logic [AW-1:0] idx;
   seq_st_t       st_q;
   op_kind_t      kind_q;
   logic          flag_w;
   logic [3:0]    mode_w;

   assign flag_w  = ctrl.flag;
   assign mode_w  = ctrl.mode;
   assign sec_sel = ahi[DW-1] && (alo == '0);
   assign idx     = alo[AW-1:0];
   assign busy    = (st_q != ST_IDLE);
   assign irq     = ctrl.flag && ctrl.ien;

   if (SKIP_CLEAN) begin : g_skip
      assign need_erase = (mem_byte != '0);
   end else begin : g_always
      assign need_erase = 1'b1;
   end

   nvbyte_regs #(.DW(DW), .SW(SW), .TIM_RST(TIM_RST), .AHI_RST(8'h80)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
      .mem_byte(mem_byte), .ctrl(ctrl), .tim(tim), .ahi(ahi), .alo(alo),
      .data(data), .go(go)
   );

   nvbyte_phase_timer #(.TW(DW), .SH(TICK_SHIFT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(busy), .tim(tim), .expire(expire)
   );

   nvbyte_array #(.AW(AW), .RW(RW), .DW(DW), .FILL(FILL)) u_arr (
      .clk(clk), .rst_n(rst_n), .idx(idx), .sec(sec_sel), .rd_byte(mem_byte),
      .wr_en(wr_en), .wr_val(data), .clr_byte(clr_byte),
      .clr_row(clr_row), .clr_all(clr_all)
   );

   assign clr_byte = (st_q == ST_ERASE) && expire && (kind_q == OP_BYTE);
   assign clr_row  = (st_q == ST_ERASE) && expire && (kind_q == OP_ROW);
   assign clr_all  = (st_q == ST_ERASE) && expire && (kind_q == OP_BLOCK);
   assign wr_en    = (st_q == ST_WRITE) && expire;
   assign done     = wr_en || clr_row || clr_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= OP_BYTE;
      end else begin
         case (st_q)
            ST_IDLE: if (go) begin
               case (ctrl.mode)
                  MODE_BYTE: begin
                     kind_q <= OP_BYTE;
                     st_q   <= need_erase ? ST_ERASE : ST_WRITE;
                  end
                  MODE_ROW: begin
                     kind_q <= OP_ROW;
                     st_q   <= ST_ERASE;
                  end
                  MODE_BLOCK: begin
                     kind_q <= OP_BLOCK;
                     st_q   <= ST_ERASE;
                  end
                  default: ;
               endcase
            end
            ST_ERASE: if (expire) st_q <= (kind_q == OP_BYTE) ? ST_WRITE : ST_IDLE;
            ST_WRITE: if (expire) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nvbyte_seq_chk.sv
module nvbyte_seq_chk #(
   parameter int DW = 8,
   parameter int SW = 8,
   parameter int SH = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          flag,
   input logic [3:0]    mode,
   input logic [DW-1:0] tim,
   input logic [DW-1:0] ahi,
   input logic [DW-1:0] alo,
   input logic          wr,
   input logic          rd,
   input logic [SW-1:0] sel,
   input logic [DW-1:0] rdata
);
   localparam int CW = DW + SH + 2;

   logic [CW-1:0] run_len;
   logic [CW-1:0] phase_len;

   assign phase_len = (CW'(tim) + 1'b1) << SH;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) run_len <= '0;
      else                 run_len <= run_len + 1'b1;
   end

   // R5 R3 R4: a busy period lasts one or two phase lengths
   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> (run_len == phase_len || run_len == (phase_len << 1)));

   p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> flag);

   p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(alo) && $stable(ahi) && $stable(mode) && $stable(tim)));

   p_busy_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == SW'(0)) |=> (rdata[5] == $past(busy) && !rdata[4]));

   p_bad_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr && sel == SW'(4) && mode != 4'h0 && mode != 4'hC && mode != 4'hA) |=> !busy);
endmodule

bind nvbyte_seq nvbyte_seq_chk #(.DW(DW), .SW(SW), .SH(TICK_SHIFT)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .flag(flag_w), .mode(mode_w),
   .tim(tim), .ahi(ahi), .alo(alo), .wr(bus_wr), .rd(bus_rd),
   .sel(bus_sel), .rdata(bus_rdata)
);

// File: tb/sim_nvbyte_seq.sv
module sim_nvbyte_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_sel = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] model [256];
   logic [7:0] msec;

   always #10 clk = ~clk;

   nvbyte_seq u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] s, input logic [7:0] v);
      bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] s, output logic [7:0] v);
      bus_sel = s; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      v = bus_rdata;
   endtask

   task automatic rd_at(input logic [7:0] a, output logic [7:0] v);
      wr_reg(8'd3, a);
      @(negedge clk);
      rd_reg(8'd4, v);
   endtask

   task automatic run_op(input logic [7:0] v, output int n, output logic fl_last, output logic fl_idle);
      logic [7:0] r;
      bit fin = 0;
      n = 0; fl_last = 0; fl_idle = 0;
      wr_reg(8'd4, v);
      while (!fin && n < 5000) begin
         rd_reg(8'd0, r);
         if (r[5]) begin n++; fl_last = r[7]; end
         else begin fl_idle = r[7]; fin = 1; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      logic fl, fi;
      int bad;
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      msec = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd_reg(8'd0, v); chk("R1 ctrl", v, 8'h00);
      rd_reg(8'd1, v); chk("R1 timing", v, 8'h08);
      rd_reg(8'd2, v); chk("R1 addr high", v, 8'h80);
      rd_reg(8'd3, v); chk("R1 addr low", v, 8'h00);
      rd_reg(8'd4, v); chk("R11 security byte after reset", v, 8'hFF);
      chk("R8 irq after reset", irq, 0);

      // R3 sweep: program every byte, erase+write each time
      wr_reg(8'd1, 8'd0);
      wr_reg(8'd2, 8'd0);
      bad = 0;
      for (int a = 0; a < 256; a++) begin
         logic [7:0] d;
         d = 8'((a * 7 + 3) & 255);
         if (d == 8'h00) d = 8'h01;
         wr_reg(8'd3, 8'(a));
         run_op(d, n, fl, fi);
         model[a] = d;
         if (n != 32) bad++;
      end
      chk("R3 erase+write busy length over sweep (mismatches)", bad, 0);

      // R2 read-back sweep
      bad = 0;
      for (int a = 0; a < 256; a++) begin
         rd_at(8'(a), v);
         if (v != model[a]) bad++;
      end
      chk("R2 byte mode read-back mismatches", bad, 0);

      // R4: write-only when byte already clear
      wr_reg(8'd3, 8'd5);
      run_op(8'h00, n, fl, fi); model[5] = 8'h00;
      chk("R3 write 00 over nonzero length", n, 32);
      run_op(8'h3C, n, fl, fi); model[5] = 8'h3C;
      chk("R4 write-only length", n, 16);
      rd_at(8'd5, v); chk("R4 value stored", v, 8'h3C);

      // R5 + R6: row erase for several timing values
      for (int t = 1; t <= 3; t++) begin
         int r;
         r = t * 2 + 1;
         wr_reg(8'd1, 8'(t));
         wr_reg(8'd3, 8'(r * 8 + (r & 7)));
         wr_reg(8'd0, 8'h0C);
         run_op(8'h5A, n, fl, fi);
         chk("R5 phase length (T+1)*16 via row erase", n, (t + 1) * 16);
         for (int k = 0; k < 8; k++) model[r * 8 + k] = 8'h00;
         wr_reg(8'd0, 8'h00);
      end
      wr_reg(8'd1, 8'd0);

      // R12: unknown mode starts nothing
      wr_reg(8'd0, 8'h03);
      wr_reg(8'd3, 8'd20);
      run_op(8'h77, n, fl, fi);
      chk("R12 no busy on unknown mode", n, 0);
      wr_reg(8'd0, 8'h00);

      bad = 0;
      for (int a = 0; a < 256; a++) begin
         rd_at(8'(a), v);
         if (v != model[a]) bad++;
      end
      chk("R6 R12 array after row erases (mismatches)", bad, 0);

      // R8 interrupt flag and enable
      wr_reg(8'd0, 8'h00);
      rd_reg(8'd0, v); chk("R8 software clear flag", v, 8'h00);
      wr_reg(8'd0, 8'h40);
      chk("R8 irq low with flag clear", irq, 0);
      wr_reg(8'd0, 8'hC0);
      chk("R8 software set raises irq", irq, 1);
      wr_reg(8'd0, 8'h40);
      chk("R8 irq drops on clear", irq, 0);
      wr_reg(8'd3, 8'd6);
      run_op(8'h81, n, fl, fi); model[6] = 8'h81;
      chk("R8 flag low while busy", fl, 0);
      chk("R8 flag set as busy drops", fi, 1);
      chk("R8 irq after completion", irq, 1);
      wr_reg(8'd0, 8'h80);
      chk("R8 irq masked by enable", irq, 0);

      // R9
      wr_reg(8'd0, 8'h30);
      rd_reg(8'd0, v); chk("R9 bits 5 and 4 not writable", v, 8'h00);

      // R10: writes while busy
      wr_reg(8'd3, 8'd9);
      wr_reg(8'd4, 8'h66);
      wr_reg(8'd3, 8'd77);
      wr_reg(8'd4, 8'h11);
      wr_reg(8'd0, 8'h0A);
      wr_reg(8'd1, 8'd9);
      rd_reg(8'd4, v); chk("R10 data reg holds programmed value", v, 8'h66);
      rd_reg(8'd3, v); chk("R10 address write ignored", v, 8'd9);
      n = 0;
      do begin rd_reg(8'd0, v); n++; end while (v[5] && n < 5000);
      chk("R10 control write ignored", v & 8'h0F, 0);
      rd_reg(8'd1, v); chk("R10 timing write ignored", v, 8'd0);
      model[9] = 8'h66;
      rd_at(8'd9, v); chk("R10 programmed byte", v, 8'h66);
      rd_at(8'd77, v); chk("R10 other byte untouched", v, model[77]);

      // R11 security byte
      wr_reg(8'd2, 8'h80);
      wr_reg(8'd3, 8'd0);
      run_op(8'hA5, n, fl, fi); msec = 8'hA5;
      chk("R11 security program length", n, 32);
      @(negedge clk);
      rd_reg(8'd4, v); chk("R11 security byte", v, 8'hA5);
      wr_reg(8'd2, 8'h00);
      @(negedge clk);
      rd_reg(8'd4, v); chk("R11 main byte 0 separate", v, model[0]);
      wr_reg(8'd2, 8'h80);
      rd_at(8'd1, v); chk("R11 high bit with nonzero low indexes array", v, model[1]);

      // R7 block erase
      wr_reg(8'd1, 8'd2);
      wr_reg(8'd0, 8'h0A);
      run_op(8'hEE, n, fl, fi);
      chk("R7 block erase length", n, 48);
      wr_reg(8'd0, 8'h00);
      wr_reg(8'd2, 8'h00);
      bad = 0;
      for (int a = 0; a < 256; a++) begin
         rd_at(8'(a), v);
         if (v != 8'h00) bad++;
      end
      chk("R7 array cleared (nonzero count)", bad, 0);
      wr_reg(8'd2, 8'h80);
      rd_at(8'd0, v); chk("R7 security byte cleared", v, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule